// File: doc/BRIEF.md
# Cadenced Ringing Waveform Generator

This block produces the digital ringing signal for a subscriber line. It runs at a 1 kHz sample rate, set by a strobe input. Two wave sources are available. The first is a two-pole resonator that gives a sinusoid. The second is a ramp-and-hold generator that gives a trapezoid. In the trapezoid, the ratio of slope to hold time sets the crest factor. The selected wave is added to a programmable dc offset and saturated to a signed 16-bit sample.

A cadence state machine with an on timer and an off timer drives the bursts of ringing. It has four states: `RS_IDLE`, `RS_ACT` (ringing), `RS_OFF` (silent part of the cadence) and `RS_DRAIN` (finishing the waveform after a stop request). All transitions happen only on a strobe. They are:

- **start:** `RS_IDLE` to `RS_ACT`
- **on-expire:** `RS_ACT` to `RS_OFF`
- **off-expire:** `RS_OFF` to `RS_ACT`
- **stop:** `RS_ACT` to `RS_DRAIN`
- **abort:** `RS_OFF` to `RS_IDLE`
- **settle:** `RS_DRAIN` to `RS_IDLE`

The ringing generator shares hardware with the second tone generator. A ringing request made while that tone generator is enabled is refused and flagged.

Software configures the block through a small write-only register port. It then raises `ring_en` and reads the samples.

Top module: `ring_cadence_gen`

## Requirements
- R1: After reset, every register is 0. `sample_out` is 0, and `ring_active`, `conflict`, `irq_on` and `irq_off` are all low.
- R2: Samples and cadence state change only on a clock edge where `tick_1k` is high. Holding `ring_en` high without a strobe does not start ringing.
- R3: In sine mode (mode bit0 = 0), the wave starts at w=0 with a previous value of −amp. Each strobe gives w' = ((coef·w) >>> 14) − w_prev, saturated to 16 bits. `coef` is 2·cos(2π·f/1000) in Q14.
- R4: In trapezoid mode (mode bit0 = 1), the wave starts at 0 and rises by `slope` per strobe, clamped at +amp. The value +amp is output on hold+1 strobes. The wave then falls by `slope` per strobe, clamped at −amp, holds there for hold+1 strobes, and rises again.
- R5: While ringing (`ring_active`=1), `sample_out` = offset + w, saturated to [−32768, 32767]. Otherwise `sample_out` equals the offset.
- R6: **start**: when `ring_en` is high and `tone2_en` is low on a strobe in `RS_IDLE`, the block enters `RS_ACT`, restarts the wave from zero and pulses `irq_on` for one clock.
- R7: **on-expire**: with a nonzero on count N, `RS_ACT` lasts N strobes. It then moves to `RS_OFF`, pulses `irq_off` and outputs the offset.
- R8: **off-expire**: `RS_OFF` lasts max(M,1) strobes for off count M. It then re-enters `RS_ACT` with the wave restarted and pulses `irq_on`.
- R9: An on count of 0 means continuous ringing: `RS_ACT` is never left by the timer.
- R10: **stop/settle/abort**: dropping the request in `RS_ACT` moves to `RS_DRAIN`. There the wave keeps stepping until the next computed value is zero or has a different sign, and then the block returns to `RS_IDLE`. Dropping the request in `RS_OFF` returns to `RS_IDLE` on the next strobe.
- R11: `conflict` is high in the clock after any cycle where both `ring_en` and `tone2_en` are high. Such a request never starts ringing, and in `RS_ACT` it acts as a stop.
- R12: The register addresses are: 0 coef, 1 amp, 2 offset, 3 slope, 4 hold (low 14 bits), 5 on count (low 14 bits), 6 off count (low 14 bits), 7 mode (bit0 selects trapezoid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| tick_1k | input | 1 | One-clock 1 kHz sample strobe |
| ring_en | input | 1 | Ringing request |
| tone2_en | input | 1 | Second tone generator enabled (shared resource) |
| sample_out | output | 16 | Signed ringing sample |
| ring_active | output | 1 | High in RS_ACT or RS_DRAIN |
| conflict | output | 1 | Ringing refused due to tone generator conflict |
| irq_on | output | 1 | Pulse on entry to RS_ACT |
| irq_off | output | 1 | Pulse on on-timer expiry |

## Verification
The hardest case to reach is the drain path. The stop request has to land at an arbitrary phase of the waveform: on the rising ramp, during the hold at a peak, or just before a sign change. Only then is the exit at the next zero crossing shown at every point. The random stimulus toggles `ring_en` and `tone2_en` on a small share of strobes across many random configurations, so stops and conflicts fall at scattered phases. Directed runs cover the continuous mode, saturation at the output and the refused start.

// File: rtl/ring_pkg.sv
package ring_pkg;
    parameter int RING_DW = 16;
    parameter int RING_TW = 14;
    parameter int RING_AW = 3;

    typedef enum logic [1:0] {RS_IDLE, RS_ACT, RS_OFF, RS_DRAIN} ring_state_e;
    typedef enum logic [1:0] {TP_RISE, TP_HIGH, TP_FALL, TP_LOW} trap_phase_e;

    typedef struct packed {
        logic signed [RING_DW-1:0] coef;
        logic signed [RING_DW-1:0] amp;
        logic signed [RING_DW-1:0] offset;
        logic signed [RING_DW-1:0] slope;
        logic [RING_TW-1:0]        hold;
        logic [RING_TW-1:0]        on_ticks;
        logic [RING_TW-1:0]        off_ticks;
        logic                      trap;
    } ring_cfg_t;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_pkg::*;
#(
    parameter int AW = RING_AW,
    parameter int DW = RING_DW,
    parameter int TW = RING_TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ring_cfg_t     cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            unique case (addr)
                3'd0: cfg.coef      <= wdata;
                3'd1: cfg.amp       <= wdata;
                3'd2: cfg.offset    <= wdata;
                3'd3: cfg.slope     <= wdata;
                3'd4: cfg.hold      <= wdata[TW-1:0];
                3'd5: cfg.on_ticks  <= wdata[TW-1:0];
                3'd6: cfg.off_ticks <= wdata[TW-1:0];
                3'd7: cfg.trap      <= wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ring_sine_osc.sv
module ring_sine_osc #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 restart,
    input  logic signed [DW-1:0] coef,
    input  logic signed [DW-1:0] amp,
    output logic signed [DW-1:0] w_q,
    output logic signed [DW-1:0] w_nxt
);
    logic signed [DW-1:0]   wp_q;
    logic signed [2*DW-1:0] prod;
    logic signed [2*DW:0]   acc;
    logic [DW+1:0]          hi;

    always_comb begin
        prod = coef * w_q;
        acc  = (prod >>> FRAC) - wp_q;
        hi   = acc[2*DW:DW-1];
        if ((&hi) || ~(|hi)) begin
            w_nxt = acc[DW-1:0];
        end else if (acc[2*DW]) begin
            w_nxt = {1'b1, {(DW-1){1'b0}}};
        end else begin
            w_nxt = {1'b0, {(DW-1){1'b1}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            wp_q <= '0;
        end else if (restart) begin
            w_q  <= '0;
            wp_q <= -amp;
        end else if (step) begin
            wp_q <= w_q;
            w_q  <= w_nxt;
        end
    end

    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (w_q == '0));
endmodule

// File: rtl/ring_trap_gen.sv
module ring_trap_gen
    import ring_pkg::*;
#(
    parameter int DW = RING_DW,
    parameter int TW = RING_TW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 restart,
    input  logic signed [DW-1:0] amp,
    input  logic signed [DW-1:0] slope,
    input  logic [TW-1:0]        hold,
    output logic signed [DW-1:0] w_q,
    output logic signed [DW-1:0] w_nxt
);
    trap_phase_e          ph_q, ph_nxt;
    logic [TW-1:0]        hc_q, hc_nxt;
    logic signed [DW:0]   up, dn, ampx;

    always_comb begin
        ampx   = {amp[DW-1], amp};
        up     = {w_q[DW-1], w_q} + {slope[DW-1], slope};
        dn     = {w_q[DW-1], w_q} - {slope[DW-1], slope};
        w_nxt  = w_q;
        ph_nxt = ph_q;
        hc_nxt = hc_q;
        unique case (ph_q)
            TP_RISE: begin
                if (up >= ampx) begin
                    w_nxt = amp; ph_nxt = TP_HIGH; hc_nxt = hold;
                end else begin
                    w_nxt = up[DW-1:0];
                end
            end
            TP_HIGH: begin
                if (hc_q != '0) begin
                    hc_nxt = hc_q - 1'b1;
                end else if (dn <= -ampx) begin
                    w_nxt = -amp; ph_nxt = TP_LOW; hc_nxt = hold;
                end else begin
                    w_nxt = dn[DW-1:0]; ph_nxt = TP_FALL;
                end
            end
            TP_FALL: begin
                if (dn <= -ampx) begin
                    w_nxt = -amp; ph_nxt = TP_LOW; hc_nxt = hold;
                end else begin
                    w_nxt = dn[DW-1:0];
                end
            end
            TP_LOW: begin
                if (hc_q != '0) begin
                    hc_nxt = hc_q - 1'b1;
                end else if (up >= ampx) begin
                    w_nxt = amp; ph_nxt = TP_HIGH; hc_nxt = hold;
                end else begin
                    w_nxt = up[DW-1:0]; ph_nxt = TP_RISE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            ph_q <= TP_RISE;
            hc_q <= '0;
        end else if (restart) begin
            w_q  <= '0;
            ph_q <= TP_RISE;
            hc_q <= '0;
        end else if (step) begin
            w_q  <= w_nxt;
            ph_q <= ph_nxt;
            hc_q <= hc_nxt;
        end
    end

    a_r4_peak_reaches_amp: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == TP_HIGH && $past(ph_q) == TP_RISE && $past(step) && !$past(restart))
            |-> (w_q == $past(amp)));
endmodule

// File: rtl/ring_cadence_gen.sv
module ring_cadence_gen
    import ring_pkg::*;
#(
    parameter int DW   = RING_DW,
    parameter int TW   = RING_TW,
    parameter int AW   = RING_AW,
    parameter int FRAC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          tick_1k,
    input  logic          ring_en,
    input  logic          tone2_en,
    output logic [DW-1:0] sample_out,
    output logic          ring_active,
    output logic          conflict,
    output logic          irq_on,
    output logic          irq_off
);
    ring_cfg_t            cfg;
    ring_state_e          st_q, st_nxt;
    logic [TW-1:0]        cnt_q, cnt_nxt;
    logic                 req, ringing, restart, step, xing;
    logic                 fire_on, fire_off;
    logic signed [DW-1:0] sw, sw_nxt, tw, tw_nxt, w_sel, w_nxt_sel;
    logic signed [DW:0]   sum;

    ring_cfg_regs #(.AW(AW), .DW(DW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    ring_sine_osc #(.DW(DW), .FRAC(FRAC)) u_sine (
        .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
        .coef(cfg.coef), .amp(cfg.amp), .w_q(sw), .w_nxt(sw_nxt)
    );

    ring_trap_gen #(.DW(DW), .TW(TW)) u_trap (
        .clk(clk), .rst_n(rst_n), .step(step), .restart(restart),
        .amp(cfg.amp), .slope(cfg.slope), .hold(cfg.hold),
        .w_q(tw), .w_nxt(tw_nxt)
    );

    assign req       = ring_en & ~tone2_en;
    assign ringing   = (st_q == RS_ACT) || (st_q == RS_DRAIN);
    assign w_sel     = cfg.trap ? tw : sw;
    assign w_nxt_sel = cfg.trap ? tw_nxt : sw_nxt;
    assign xing      = (w_nxt_sel[DW-1] != w_sel[DW-1]) || (w_nxt_sel == '0);
    assign step      = tick_1k && ringing && !restart;

    // next-state process
    always_comb begin
        st_nxt   = st_q;
        cnt_nxt  = cnt_q;
        restart  = 1'b0;
        fire_on  = 1'b0;
        fire_off = 1'b0;
        if (tick_1k) begin
            unique case (st_q)
                RS_IDLE: begin
                    if (req) begin
                        st_nxt = RS_ACT; cnt_nxt = cfg.on_ticks;
                        restart = 1'b1; fire_on = 1'b1;
                    end
                end
                RS_ACT: begin
                    if (!req) begin
                        st_nxt = RS_DRAIN;
                    end else if (cfg.on_ticks != '0) begin
                        if (cnt_q <= TW'(1)) begin
                            st_nxt = RS_OFF; cnt_nxt = cfg.off_ticks;
                            fire_off = 1'b1;
                        end else begin
                            cnt_nxt = cnt_q - 1'b1;
                        end
                    end
                end
                RS_OFF: begin
                    if (!req) begin
                        st_nxt = RS_IDLE;
                    end else if (cnt_q <= TW'(1)) begin
                        st_nxt = RS_ACT; cnt_nxt = cfg.on_ticks;
                        restart = 1'b1; fire_on = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q - 1'b1;
                    end
                end
                RS_DRAIN: begin
                    if (xing) st_nxt = RS_IDLE;
                end
                default: st_nxt = RS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // registered status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_on   <= 1'b0;
            irq_off  <= 1'b0;
            conflict <= 1'b0;
        end else begin
            irq_on   <= fire_on;
            irq_off  <= fire_off;
            conflict <= ring_en & tone2_en;
        end
    end

    always_comb begin
        sum = {cfg.offset[DW-1], cfg.offset} + {w_sel[DW-1], w_sel};
        if (!ringing) begin
            sample_out = cfg.offset;
        end else if (sum[DW] != sum[DW-1]) begin
            sample_out = sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            sample_out = sum[DW-1:0];
        end
    end

    assign ring_active = ringing;

    a_r2_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> $past(tick_1k));
    a_r6_irq_on_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_on |-> (st_q == RS_ACT));
    a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_on && irq_off));
    a_r11_no_start_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_active) |-> !conflict);
    a_r10_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_DRAIN) |=> (st_q == RS_DRAIN || st_q == RS_IDLE));
endmodule

// File: tb/ring_cadence_gen_tb.sv
module ring_cadence_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tick_1k = 1'b0;
    logic        ring_en = 1'b0;
    logic        tone2_en = 1'b0;
    logic [15:0] sample_out;
    logic        ring_active, conflict, irq_on, irq_off;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // shadow config
    longint c_coef, c_amp, c_off, c_slope;
    int c_hold, c_on, c_offt, c_trap;
    // model state: 0 idle 1 act 2 off 3 drain
    int ms, mcnt;
    longint sw, swp, tw;
    int tph, thc;
    bit e_irq_on, e_irq_off, e_conf;

    always #5 clk = ~clk;

    ring_cadence_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tick_1k(tick_1k), .ring_en(ring_en),
        .tone2_en(tone2_en), .sample_out(sample_out), .ring_active(ring_active),
        .conflict(conflict), .irq_on(irq_on), .irq_off(irq_off)
    );

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint s16(longint v);
        return longint'($signed(16'(v)));
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, longint d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: c_coef = s16(d);
            1: c_amp = s16(d);
            2: c_off = s16(d);
            3: c_slope = s16(d);
            4: c_hold = int'(d) & 16'h3fff;
            5: c_on = int'(d) & 16'h3fff;
            6: c_offt = int'(d) & 16'h3fff;
            default: c_trap = int'(d) & 1;
        endcase
    endtask

    task automatic model_step(bit en, bit t2);
        bit req, ringing, restart, xing;
        longint snx, tnx, wsel, wnx;
        int tpn, thn;
        req = en && !t2;
        ringing = (ms == 1 || ms == 3);
        snx = sat16(((c_coef * sw) >>> 14) - swp);
        tnx = tw; tpn = tph; thn = thc;
        case (tph)
            0: if (tw + c_slope >= c_amp) begin tnx = c_amp; tpn = 1; thn = c_hold; end
               else tnx = tw + c_slope;
            1: if (thc != 0) thn = thc - 1;
               else if (tw - c_slope <= -c_amp) begin tnx = -c_amp; tpn = 3; thn = c_hold; end
               else begin tnx = tw - c_slope; tpn = 2; end
            2: if (tw - c_slope <= -c_amp) begin tnx = -c_amp; tpn = 3; thn = c_hold; end
               else tnx = tw - c_slope;
            default: if (thc != 0) thn = thc - 1;
               else if (tw + c_slope >= c_amp) begin tnx = c_amp; tpn = 1; thn = c_hold; end
               else begin tnx = tw + c_slope; tpn = 0; end
        endcase
        wsel = c_trap ? tw : sw;
        wnx  = c_trap ? tnx : snx;
        xing = ((wnx < 0) != (wsel < 0)) || (wnx == 0);
        restart = 0; e_irq_on = 0; e_irq_off = 0;
        case (ms)
            0: if (req) begin ms = 1; mcnt = c_on; restart = 1; e_irq_on = 1; end
            1: if (!req) ms = 3;
               else if (c_on != 0) begin
                   if (mcnt <= 1) begin ms = 2; mcnt = c_offt; e_irq_off = 1; end
                   else mcnt--;
               end
            2: if (!req) ms = 0;
               else if (mcnt <= 1) begin ms = 1; mcnt = c_on; restart = 1; e_irq_on = 1; end
               else mcnt--;
            default: if (xing) ms = 0;
        endcase
        if (restart) begin
            sw = 0; swp = -c_amp; tw = 0; tph = 0; thc = 0;
        end else if (ringing) begin
            swp = sw; sw = snx; tw = tnx; tph = tpn; thc = thn;
        end
        e_conf = en && t2;
    endtask

    function automatic longint exp_sample();
        if (ms == 1 || ms == 3) return sat16(c_off + (c_trap ? tw : sw));
        return c_off;
    endfunction

    // one strobe with given inputs, then full comparison
    task automatic tk(bit en, bit t2, string tag);
        @(negedge clk);
        ring_en = en; tone2_en = t2; tick_1k = 1'b1;
        model_step(en, t2);
        @(negedge clk);
        tick_1k = 1'b0;
        chk({tag, " sample"}, longint'($signed(sample_out)), exp_sample());
        chk({tag, " active"}, ring_active, (ms == 1 || ms == 3));
        chk({tag, " irq_on"}, irq_on, e_irq_on);
        chk({tag, " irq_off"}, irq_off, e_irq_off);
        chk({tag, " conflict"}, conflict, e_conf);
    endtask

    task automatic go_idle();
        for (int i = 0; i < 2000 && ms != 0; i++) tk(0, 0, "R10 drain");
    endtask

    initial begin
        ms = 0; mcnt = 0; sw = 0; swp = 0; tw = 0; tph = 0; thc = 0;
        c_coef = 0; c_amp = 0; c_off = 0; c_slope = 0;
        c_hold = 0; c_on = 0; c_offt = 0; c_trap = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sample", longint'($signed(sample_out)), 0);
        chk("R1 active", ring_active, 0);
        chk("R1 irq", irq_on | irq_off, 0);
        chk("R1 conflict", conflict, 0);

        // R12 register map, trapezoid config
        wr(1, 100); wr(3, 40); wr(4, 2); wr(2, 10); wr(5, 12); wr(6, 3); wr(7, 1);
        chk("R12/R5 idle offset", longint'($signed(sample_out)), 10);

        // R2: enable without strobe does nothing
        @(negedge clk); ring_en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 no start without tick", ring_active, 0);

        // R6 start, R4 ramp, R7/R8 cadence
        tk(1, 0, "R6 start");
        chk("R6 irq_on", irq_on, 1);
        tk(1, 0, "R4 ramp");
        chk("R4 first step", longint'($signed(sample_out)), 50);
        tk(1, 0, "R4 ramp");
        chk("R4 second step", longint'($signed(sample_out)), 90);
        tk(1, 0, "R4 clamp");
        chk("R4 clamp at amp", longint'($signed(sample_out)), 110);
        for (int i = 0; i < 40; i++) tk(1, 0, "R7/R8 cadence");

        // R10 stop in active -> drain
        go_idle();
        tk(1, 0, "R6 restart");
        tk(1, 0, "R10 ramp");
        tk(0, 0, "R10 stop");
        chk("R10 draining", ring_active, 1);
        go_idle();
        chk("R10 settled", ring_active, 0);

        // R11 conflict
        tk(1, 1, "R11 refuse");
        chk("R11 conflict set", conflict, 1);
        chk("R11 not ringing", ring_active, 0);

        // R3/R9 sine continuous
        wr(7, 0); wr(0, 32510); wr(1, 1000); wr(5, 0); wr(2, 0);
        for (int i = 0; i < 300; i++) tk(1, 0, "R3/R9 sine");
        chk("R9 still active", ring_active, 1);
        go_idle();

        // R5 saturation
        wr(7, 1); wr(2, 32000); wr(1, 2000); wr(3, 1000); wr(4, 1);
        tk(1, 0, "R5 sat");
        tk(1, 0, "R5 sat");
        tk(1, 0, "R5 sat");
        chk("R5 saturated high", longint'($signed(sample_out)), 32767);
        go_idle();

        // random episodes
        for (int ep = 0; ep < 40; ep++) begin
            go_idle();
            wr(7, $urandom_range(1, 0));
            wr(0, $urandom_range(32700, 30000));
            wr(1, $urandom_range(3000, 50));
            wr(2, longint'($urandom_range(4000, 0)) - 2000);
            wr(3, $urandom_range(500, 20));
            wr(4, $urandom_range(5, 0));
            wr(5, ($urandom_range(9, 0) == 0) ? 0 : $urandom_range(30, 1));
            wr(6, $urandom_range(10, 0));
            begin
                bit en;
                en = 1;
                for (int i = 0; i < 120; i++) begin
                    if ($urandom_range(19, 0) == 0) en = !en;
                    tk(en, ($urandom_range(32, 0) == 0), "R3/R4/R7/R8/R10/R11 random");
                end
            end
        end
        go_idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule